// File: doc/BRIEF.md
# Prioritised Thirty-Two Source Interrupt Controller

This block gathers thirty-two interrupt request lines and presents them to a processor as two request outputs: an ordinary interrupt and a critical (machine-check class) interrupt. Each line is first passed through a two-stage synchroniser. It is then judged against its own sense setting (level or edge) and its own polarity setting (active high and rising, or active low and falling). Each line is also routed to one of the two outputs. Detected requests collect in a sticky status word that software clears by writing ones. An enable word gates which status bits reach the outputs.

A small word-addressed register bus gives access to status, enable, routing, polarity, sense, the gated (masked) status, a priority-order setting and the current vector. The vector is the number of the highest-priority request in masked status. Source numbering runs from the most significant bit downward. Sources 17, 18 and 19 do not exist: their bits stay zero in every register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source n occupies bit (31 − n) of every register, so source 0 is bit 31 and source 31 is bit 0.
- R2: Bits 14, 13 and 12 (sources 17, 18, 19) read as zero in every register even after writing ones, and never set status or drive an output.
- R3: Writing status at offset 0x00 clears every bit written as 1. Bits written as 0 are left unchanged. A status bit that is not cleared never falls by itself.
- R4: Sense register (offset 0x10) bit value 0 selects level sensing and 1 selects edge sensing. An edge source sets status once per qualifying edge, ignores the opposite edge, and does not set again while its input stays at the new level.
- R5: Polarity register (offset 0x0C) bit value 1 means active high or rising edge. Bit value 0 means active low or falling edge.
- R6: A level source sets its status bit on every cycle its synchronised input is active, so clearing that bit has no lasting effect while the input remains active.
- R7: Routing register (offset 0x08) bit value 1 sends a source to `irq_norm_o` and 0 sends it to `irq_crit_o`. Each output is the registered OR of the masked-status bits routed to it.
- R8: Masked status (offset 0x14, read-only) equals status AND enable (offset 0x04). An enable of zero holds both outputs low and the vector invalid.
- R9: Vector-config (offset 0x18) bit 0 = 0 gives source 0 the highest priority; bit 0 = 1 gives source 31 the highest priority. The vector (offset 0x1C, read-only) returns the winning source number in bits 4:0 and a valid flag in bit 5, and matches `vec_idx_o` and `vec_valid_o`. When no source is pending it reads 0.
- R10: A read (`bus_sel`=1, `bus_wr`=0) returns data with `bus_rvalid` high exactly one cycle later. `bus_rvalid` is low in every other cycle. Writes take effect at the clock edge that samples them.
- R11: Reset clears enable, polarity, sense, vector-config and status, and sets routing to all valid sources (0xFFFF8FFF).
- R12: An input change sets status at the third rising edge after it. The output outputs and vector follow one edge later, at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw request lines, source n on bit 31−n |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_norm_o | output | 1 | Ordinary interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |
| vec_idx_o | output | 5 | Highest-priority pending source number |
| vec_valid_o | output | 1 | A masked source is pending |

## Verification
The bench targets the reversed bit numbering. A design that used bit n for source n would show a request on the wrong status bit and name the wrong vector. It also probes the reserved positions, which a careless design would let hold written ones. For edge sources it drives the opposite edge and then holds the active level: a design that confused level and edge sensing would re-set status after a clear, and one with inverted polarity would fire on the wrong edge. It checks the exact cycle of the third and fourth edge after an input change, which catches a missing or extra synchroniser stage. It also flips the priority order with two requests pending, which exposes an encoder that ignores the order setting.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_norm_o,
  output logic              irq_crit_o,
  output logic [4:0]        vec_idx_o,
  output logic              vec_valid_o
);

  localparam logic [31:0] RSV  = (32'h1 << (31 - 17)) | (32'h1 << (31 - 18)) | (32'h1 << (31 - 19));
  localparam logic [31:0] LIVE = ~RSV;
  localparam int A_STAT = 0, A_EN = 1, A_ROUTE = 2, A_POL = 3;
  localparam int A_TRIG = 4, A_MSK = 5, A_VCFG = 6, A_VEC = 7;

  logic [31:0] sync_q [SYNC_STAGES];
  logic [31:0] prev_q;
  logic [31:0] stat_q, en_q, route_q, pol_q, trig_q;
  logic        vcfg_q;
  logic [31:0] rdata_q;
  logic        rvalid_q, norm_q, crit_q, vval_q;
  logic [4:0]  vidx_q;

  logic [ADDR_W-3:0] widx;
  logic              wr, rd, unused_lsb;
  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr         = bus_sel & bus_wr;
  assign rd         = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= irq_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  logic [31:0] cur, lvl_hit, edge_hit, set_vec, clr_vec, masked;
  assign cur      = sync_q[SYNC_STAGES-1];
  assign lvl_hit  = ~(cur ^ pol_q);
  assign edge_hit = (cur ^ prev_q) & lvl_hit;
  assign set_vec  = LIVE & ((trig_q & edge_hit) | (~trig_q & lvl_hit));
  assign clr_vec  = (wr && int'(widx) == A_STAT) ? bus_wdata : 32'h0;
  assign masked   = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      route_q <= LIVE;
      pol_q   <= '0;
      trig_q  <= '0;
      vcfg_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      if (wr) begin
        case (int'(widx))
          A_EN:    en_q    <= bus_wdata & LIVE;
          A_ROUTE: route_q <= bus_wdata & LIVE;
          A_POL:   pol_q   <= bus_wdata & LIVE;
          A_TRIG:  trig_q  <= bus_wdata & LIVE;
          A_VCFG:  vcfg_q  <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  logic       hit;
  logic [4:0] pick;
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int n = 0; n < 32; n++) begin
      if (!vcfg_q) begin
        if (!hit && masked[31-n]) begin
          hit  = 1'b1;
          pick = 5'(n);
        end
      end else if (!hit && masked[n]) begin
        hit  = 1'b1;
        pick = 5'(31 - n);
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (int'(widx))
      A_STAT:  rd_mux = stat_q;
      A_EN:    rd_mux = en_q;
      A_ROUTE: rd_mux = route_q;
      A_POL:   rd_mux = pol_q;
      A_TRIG:  rd_mux = trig_q;
      A_MSK:   rd_mux = masked;
      A_VCFG:  rd_mux = {31'h0, vcfg_q};
      A_VEC:   rd_mux = {26'h0, vval_q, vidx_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      norm_q   <= 1'b0;
      crit_q   <= 1'b0;
      vidx_q   <= '0;
      vval_q   <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
      norm_q   <= |(masked & route_q);
      crit_q   <= |(masked & ~route_q & LIVE);
      vidx_q   <= pick;
      vval_q   <= hit;
    end
  end

  assign bus_rdata   = rdata_q;
  assign bus_rvalid  = rvalid_q;
  assign irq_norm_o  = norm_q;
  assign irq_crit_o  = crit_q;
  assign vec_idx_o   = vidx_q;
  assign vec_valid_o = vval_q;

endmodule

module prio_irq_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       stat_q,
  input logic [31:0]       en_q,
  input logic [31:0]       route_q,
  input logic [31:0]       set_vec,
  input logic              bus_rvalid,
  input logic              irq_norm_o,
  input logic              irq_crit_o,
  input logic              vec_valid_o
);
  localparam logic [31:0] RSV  = (32'h1 << (31 - 17)) | (32'h1 << (31 - 18)) | (32'h1 << (31 - 19));
  localparam logic [31:0] LIVE = ~RSV;

  logic wr_stat, rd_req, unused_lsb;
  assign wr_stat    = bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == '0;
  assign rd_req     = bus_sel && !bus_wr;
  assign unused_lsb = ^bus_addr[1:0];

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | en_q | route_q) & RSV) == 0); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_q & $past(bus_wdata) & ~$past(set_vec)) == 0); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ($past(stat_q) & ~stat_q) == 0); // R3
  AST_NORM_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> $past(route_q != 0)); // R7
  AST_CRIT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit_o |-> $past(route_q != LIVE)); // R7
  AST_EN_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 0) |=> !irq_norm_o && !irq_crit_o && !vec_valid_o); // R8
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R10
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_q(stat_q), .en_q(en_q),
  .route_q(route_q), .set_vec(set_vec), .bus_rvalid(bus_rvalid),
  .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o), .vec_valid_o(vec_valid_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LIVE = 32'hFFFF8FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_in = 32'hFFFFFFFF;
  logic bsel = 1'b0, bwr = 1'b0;
  logic [4:0] baddr = '0;
  logic [31:0] bwdata = '0;
  logic [31:0] rdata;
  logic rvalid, norm, crit, vval;
  logic [4:0] vidx;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bsel), .bus_wr(bwr),
    .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .irq_norm_o(norm), .irq_crit_o(crit), .vec_idx_o(vidx), .vec_valid_o(vval)
  );

  // behavioural reference
  logic [31:0] m_stat, m_en, m_route, m_pol, m_trig, m_rdata, nstat, msk;
  logic m_vcfg, m_rvalid, m_norm, m_crit, m_vval;
  logic [4:0] m_vidx;
  logic [31:0] hist[$];

  function automatic bit rsv(int s); return s >= 17 && s <= 19; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_route = LIVE; m_pol = 0; m_trig = 0; m_vcfg = 0;
      m_rvalid = 0; m_rdata = 0; m_norm = 0; m_crit = 0; m_vidx = 0; m_vval = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      msk = m_stat & m_en;
      m_rvalid = bsel && !bwr;
      if (m_rvalid)
        case (baddr[4:2])
          0: m_rdata = m_stat;  1: m_rdata = m_en;   2: m_rdata = m_route;
          3: m_rdata = m_pol;   4: m_rdata = m_trig; 5: m_rdata = msk;
          6: m_rdata = {31'h0, m_vcfg};
          default: m_rdata = {26'h0, m_vval, m_vidx};
        endcase
      m_norm = 0; m_crit = 0; m_vval = 0; m_vidx = 0;
      for (int k = 0; k < 32; k++) begin
        int s;
        s = m_vcfg ? 31 - k : k;
        if (msk[31-s]) begin
          if (m_route[31-s]) m_norm = 1; else m_crit = 1;
          if (!m_vval) begin m_vval = 1; m_vidx = 5'(s); end
        end
      end
      nstat = m_stat;
      for (int s = 0; s < 32; s++) begin
        int b;
        bit act, edg, setb;
        b = 31 - s;
        if (!rsv(s)) begin
          act = (hist[1][b] == m_pol[b]);
          edg = act && (hist[1][b] != hist[2][b]);
          setb = m_trig[b] ? edg : act;
          if (bsel && bwr && baddr[4:2] == 0 && bwdata[b]) nstat[b] = 0;
          if (setb) nstat[b] = 1;
        end
      end
      m_stat = nstat;
      if (bsel && bwr)
        case (baddr[4:2])
          1: m_en = bwdata & LIVE;    2: m_route = bwdata & LIVE;
          3: m_pol = bwdata & LIVE;   4: m_trig = bwdata & LIVE;
          6: m_vcfg = bwdata[0];
          default: ;
        endcase
      hist.push_front(irq_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R10 rvalid", 32'(rvalid), 32'(m_rvalid));
    if (m_rvalid) chk("R10 rdata", rdata, m_rdata);
    chk("R7 R12 norm", 32'(norm), 32'(m_norm));
    chk("R7 R12 crit", 32'(crit), 32'(m_crit));
    chk("R9 vec", {26'h0, vval, vidx}, {26'h0, m_vval, m_vidx});
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bsel = 1; bwr = 1; baddr = a; bwdata = d;
    @(negedge clk); bsel = 0; bwr = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bsel = 1; bwr = 0; baddr = a;
    @(negedge clk); bsel = 0;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(4); rst_n = 1;
    // R11 reset values
    rd_chk(5'h04, 32'h0, "R11 enable");
    rd_chk(5'h08, LIVE, "R11 route");
    rd_chk(5'h0C, 32'h0, "R11 polarity");
    rd_chk(5'h10, 32'h0, "R11 sense");
    rd_chk(5'h18, 32'h0, "R11 vcfg");
    idle(3);
    wr_reg(5'h00, 32'hFFFFFFFF); idle(2);
    rd_chk(5'h00, 32'h0, "R3 clear all");
    wr_reg(5'h00, 32'h0);
    rd_chk(5'h00, 32'h0, "R3 write zero");
    wr_reg(5'h04, 32'hFFFFFFFF);
    rd_chk(5'h04, LIVE, "R2 reserved enable");
    wr_reg(5'h0C, 32'hFFFFFFFF);
    rd_chk(5'h0C, LIVE, "R2 reserved polarity");
    wr_reg(5'h04, 32'h0); wr_reg(5'h0C, 32'h0); idle(4);
    wr_reg(5'h00, 32'hFFFFFFFF); idle(2);
    // R1 / R5: source 0 active high, input high
    wr_reg(5'h0C, 32'h80000000); idle(4);
    rd_chk(5'h00, 32'h80000000, "R1 R5 source0 bit31");
    wr_reg(5'h00, 32'h80000000); idle(2);
    rd_chk(5'h00, 32'h80000000, "R6 level re-sets");
    wr_reg(5'h0C, 32'h0); idle(2);
    wr_reg(5'h00, 32'hFFFFFFFF); idle(2);
    rd_chk(5'h00, 32'h0, "R3 cleared after inactive");
    // R4 edge sources 5 (bit26, rising) and 8 (bit23, falling)
    wr_reg(5'h10, 32'h04800000);
    wr_reg(5'h0C, 32'h04000000); idle(2);
    irq_in[26] = 0; idle(5);
    rd_chk(5'h00, 32'h0, "R4 opposite edge ignored");
    irq_in[26] = 1; idle(5);
    rd_chk(5'h00, 32'h04000000, "R4 rising edge");
    wr_reg(5'h00, 32'h04000000); idle(5);
    rd_chk(5'h00, 32'h0, "R4 no retrigger on level");
    irq_in[26] = 0; idle(4); irq_in[26] = 1; idle(5);
    irq_in[23] = 0; idle(5);
    rd_chk(5'h00, 32'h04800000, "R5 falling edge");
    // R8 / R7
    wr_reg(5'h04, 32'h00800000);
    rd_chk(5'h14, 32'h00800000, "R8 masked");
    idle(3);
    chk("R7 normal route", {30'h0, norm, crit}, 32'h2);
    wr_reg(5'h08, LIVE & ~32'h00800000); idle(3);
    chk("R7 critical route", {30'h0, norm, crit}, 32'h1);
    // R9 priority
    wr_reg(5'h04, 32'h04800000); idle(3);
    rd_chk(5'h1C, 32'h25, "R9 source0-first");
    chk("R9 port idx", 32'(vidx), 32'd5);
    wr_reg(5'h18, 32'h1); idle(3);
    rd_chk(5'h1C, 32'h28, "R9 source31-first");
    wr_reg(5'h04, 32'h0); idle(3);
    rd_chk(5'h1C, 32'h0, "R8 R9 none enabled");
    chk("R8 outputs low", {30'h0, norm, crit}, 32'h0);
    // R12 latency
    wr_reg(5'h08, LIVE); wr_reg(5'h18, 32'h0);
    wr_reg(5'h04, 32'h04000000);
    irq_in[26] = 0; idle(5);
    wr_reg(5'h00, 32'hFFFFFFFF);
    irq_in[26] = 1;
    idle(3); chk("R12 not before fourth edge", 32'(norm), 32'd0);
    idle(1); chk("R12 at fourth edge", 32'(norm), 32'd1);
    idle(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule